// File: doc/BRIEF.md
# TDM Serial Stream Transmitter

This block turns per-channel bytes into one serial time-division stream that is locked to a frame sync pulse. It runs on a clock of 32.768 MHz × 2, which is four clock cycles per bit at the fastest line rate. A two-bit rate code selects 2.048, 4.096, 8.192 or 16.384 Mbps, giving 32, 64, 128 or 256 channels per frame. The frame always lasts 8192 clock cycles. Bits can go out most-significant first or least-significant first.

To offset wire delay, the stream can be launched ahead of the frame boundary. The lead is set in whole bits (0 to 7) plus quarter bits (0 to 3). The lead in quarter-bit ticks is 4 × whole + quarter. A quarter bit lasts 2^(3 − rate) clocks. The block fetches each byte through a valid/ready request channel. It names the channel one whole channel time before that channel's first bit leaves. A transmit-enable output stays low until the stream is known to be correctly framed.

Back-pressure rules:
- `req_valid` with `req_chan` stays asserted until the requester sees `req_ready`. A request still pending when the next channel boundary arrives is replaced by the request for the following channel.
- The response path has no ready signal. The block accepts `rsp_valid`/`rsp_data` on any cycle except a channel-start cycle, where the response is dropped.
- The responder answers each accepted request exactly once, before the next request is issued.

Top module: `tdm_stream_tx`

## Requirements
- R1: While reset is asserted, `tx_en` is 0, `tx_data` is 1 and `req_valid` is 0. Whenever `tx_en` is 0, `tx_data` is 1.
- R2: With `lsb_first` = 0, each channel's byte goes out bit 7 first and bit 0 last.
- R3: With `lsb_first` = 1, each channel's byte goes out bit 0 first and bit 7 last.
- R4: For rate code r (0..3), the frame holds 32·2^r channels. Each bit lasts 4·2^(3−r) clocks, and `req_chan` is always below 32·2^r.
- R5: The frame boundary is the cycle right after the clock edge that samples `frame_sync` high; call it position 0. At position p, the line carries the bit at stream time (p + (4·`adv_whole` + `adv_quarter`)·2^(3−r)) mod 8192. Stream time 0 is channel 0's first bit.
- R6: A request for channel c+1 (mod channel count) is issued on the first cycle of channel c's slot. It is held until `req_ready`.
- R7: A channel whose byte was not returned before its slot starts is sent as all ones.
- R8: `tx_en` rises exactly at the start of channel 0's slot, in the first frame whose channel-0 request was issued after a frame pulse was seen. It then stays high while the configuration is stable and frame pulses stay aligned.
- R9: Any change of `rate_sel`, `lsb_first`, `adv_whole` or `adv_quarter` clears `tx_en` in the next cycle. A new lock then follows R8.
- R10: A `frame_sync` pulse that arrives anywhere other than the last position of the frame clears `tx_en` in the next cycle and re-aligns the frame to it.
- R11: Channel slots follow one another with no gap or overlap. The last channel ends exactly where channel 0 of the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four cycles per bit at the fastest rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle frame pulse, sampled on the clock edge |
| rate_sel | input | 2 | Rate code r: 0 = 2.048, 1 = 4.096, 2 = 8.192, 3 = 16.384 Mbps |
| lsb_first | input | 1 | 0 = bit 7 first, 1 = bit 0 first |
| adv_whole | input | 3 | Launch lead in whole bits |
| adv_quarter | input | 2 | Extra launch lead in quarter bits |
| req_valid | output | 1 | Byte request pending |
| req_ready | input | 1 | Requester accepts the pending request |
| req_chan | output | 8 | Channel whose byte is requested |
| rsp_valid | input | 1 | Requested byte is present on `rsp_data` |
| rsp_data | input | 8 | Requested byte |
| tx_data | output | 1 | Serial output stream |
| tx_en | output | 1 | Stream is framed and valid |

## Verification
The hardest case to reach is a channel whose fetch never completes. The bench's responder refuses one chosen channel number. That channel's request then stays pending until the next slot boundary replaces it, and the bench expects that slot to carry all ones while its neighbours carry their normal bytes. The same run uses a non-zero whole and quarter lead at 8.192 Mbps, so the stalled slot falls at a shifted position in the frame. A second hard case is a frame pulse that arrives early, which the bench injects in mid-frame.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int TX_BYTE_W      = 8;
  localparam int TX_BASE_CHANS  = 32;
  localparam int TX_RATE_LEVELS = 4;
  localparam int TX_QTR_W       = 2;

  typedef enum logic {
    ORDER_MSB_FIRST = 1'b0,
    ORDER_LSB_FIRST = 1'b1
  } bit_order_e;
endpackage

// File: rtl/tdm_tx_timebase.sv
module tdm_tx_timebase
  import tdm_tx_pkg::*;
#(
  parameter int BYTE_W      = TX_BYTE_W,
  parameter int BASE_CHANS  = TX_BASE_CHANS,
  parameter int RATE_LEVELS = TX_RATE_LEVELS,
  localparam int RATE_W = $clog2(RATE_LEVELS),
  localparam int BIT_SH = $clog2(BYTE_W),
  localparam int BASE_SH = $clog2(BASE_CHANS),
  localparam int CH_W   = BASE_SH + RATE_LEVELS - 1,
  localparam int ADV_W  = BIT_SH + TX_QTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [ADV_W-1:0]  adv_ticks,
  output logic              chan_start,
  output logic [CH_W-1:0]   ch_idx,
  output logic [CH_W-1:0]   ch_next,
  output logic [BIT_SH-1:0] bit_idx,
  output logic              sync_slip
);
  // frame length in clocks is a power of two, so positions wrap by truncation
  localparam int POS_W = CH_W + BIT_SH + TX_QTR_W;

  logic [POS_W-1:0]  pos_q, pos_n, stream_t, slot_off;
  logic [RATE_W-1:0] q_sh;
  int unsigned       slot_sh, bit_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_n;
  end

  always_comb begin
    q_sh      = RATE_W'(RATE_LEVELS - 1) - rate_sel;
    pos_n     = frame_sync ? '0 : pos_q + 1'b1;
    sync_slip = frame_sync && (pos_q != '1);
    // stream time runs ahead of frame position by the programmed lead
    stream_t  = pos_n + (POS_W'(adv_ticks) << q_sh);
    slot_sh   = BIT_SH + TX_QTR_W + int'(q_sh);
    bit_sh    = TX_QTR_W + int'(q_sh);
    slot_off  = stream_t & ~({POS_W{1'b1}} << slot_sh);
    chan_start = (slot_off == '0);
    ch_idx    = CH_W'(stream_t >> slot_sh);
    bit_idx   = BIT_SH'(slot_off >> bit_sh);
    ch_next   = (ch_idx + 1'b1) & ~({CH_W{1'b1}} << (BASE_SH + int'(rate_sel)));
  end
endmodule

// File: rtl/tdm_tx_fetch.sv
module tdm_tx_fetch #(
  parameter int BYTE_W = 8,
  parameter int CH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_start,
  input  logic [CH_W-1:0]   ch_next,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CH_W-1:0]   req_chan,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic [BYTE_W-1:0] next_byte,
  output logic              next_ok
);
  logic              req_valid_q;
  logic [CH_W-1:0]   req_chan_q;
  logic [BYTE_W-1:0] hold_q;
  logic              hold_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid_q <= 1'b0;
      req_chan_q  <= '0;
      hold_q      <= '1;
      hold_ok_q   <= 1'b0;
    end else if (chan_start) begin
      // a fresh slot: ask for the following channel, forget the consumed byte
      req_valid_q <= 1'b1;
      req_chan_q  <= ch_next;
      hold_ok_q   <= 1'b0;
    end else begin
      if (req_valid_q && req_ready) req_valid_q <= 1'b0;
      if (rsp_valid) begin
        hold_q    <= rsp_data;
        hold_ok_q <= 1'b1;
      end
    end
  end

  assign req_valid = req_valid_q;
  assign req_chan  = req_chan_q;
  assign next_byte = hold_q;
  assign next_ok   = hold_ok_q;
endmodule

// File: rtl/tdm_tx_serial.sv
module tdm_tx_serial
  import tdm_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BIT_SH = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_start,
  input  logic [BIT_SH-1:0] bit_idx,
  input  bit_order_e        order,
  input  logic [BYTE_W-1:0] next_byte,
  input  logic              next_ok,
  input  logic              drive,
  output logic              tx_data
);
  logic [BYTE_W-1:0] cur_q, sel;
  logic              bit_v;

  always_comb begin
    if (chan_start) sel = next_ok ? next_byte : '1;
    else            sel = cur_q;
    if (order == ORDER_LSB_FIRST) bit_v = sel[bit_idx];
    else                          bit_v = sel[BIT_SH'(BYTE_W - 1) - bit_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '1;
      tx_data <= 1'b1;
    end else begin
      if (chan_start) cur_q <= sel;
      tx_data <= drive ? bit_v : 1'b1;
    end
  end
endmodule

// File: rtl/tdm_stream_tx.sv
module tdm_stream_tx
  import tdm_tx_pkg::*;
#(
  parameter int BYTE_W      = TX_BYTE_W,
  parameter int BASE_CHANS  = TX_BASE_CHANS,
  parameter int RATE_LEVELS = TX_RATE_LEVELS,
  localparam int RATE_W = $clog2(RATE_LEVELS),
  localparam int BIT_SH = $clog2(BYTE_W),
  localparam int CH_W   = $clog2(BASE_CHANS) + RATE_LEVELS - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_sync,
  input  logic [RATE_W-1:0]   rate_sel,
  input  logic                lsb_first,
  input  logic [BIT_SH-1:0]   adv_whole,
  input  logic [TX_QTR_W-1:0] adv_quarter,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [CH_W-1:0]     req_chan,
  input  logic                rsp_valid,
  input  logic [BYTE_W-1:0]   rsp_data,
  output logic                tx_data,
  output logic                tx_en
);
  localparam int CFG_W = RATE_W + 1 + BIT_SH + TX_QTR_W;

  logic              chan_start, sync_slip, next_ok;
  logic [CH_W-1:0]   ch_idx, ch_next;
  logic [BIT_SH-1:0] bit_idx;
  logic [BYTE_W-1:0] next_byte;
  logic [CFG_W-1:0]  cfg_now, cfg_q;
  logic              armed_q, armed_n, primed_q, primed_n, en_q, en_n;

  assign cfg_now = {rate_sel, lsb_first, adv_whole, adv_quarter};

  tdm_tx_timebase #(.BYTE_W(BYTE_W), .BASE_CHANS(BASE_CHANS), .RATE_LEVELS(RATE_LEVELS)) u_tb (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_sel(rate_sel),
    .adv_ticks({adv_whole, adv_quarter}), .chan_start(chan_start), .ch_idx(ch_idx),
    .ch_next(ch_next), .bit_idx(bit_idx), .sync_slip(sync_slip)
  );

  tdm_tx_fetch #(.BYTE_W(BYTE_W), .CH_W(CH_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .chan_start(chan_start), .ch_next(ch_next),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .next_byte(next_byte), .next_ok(next_ok)
  );

  tdm_tx_serial #(.BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .chan_start(chan_start), .bit_idx(bit_idx),
    .order(bit_order_e'(lsb_first)), .next_byte(next_byte), .next_ok(next_ok),
    .drive(en_n), .tx_data(tx_data)
  );

  // lock sequence: pulse seen -> channel-0 byte requested -> channel-0 slot starts
  always_comb begin
    armed_n  = armed_q;
    primed_n = primed_q;
    en_n     = en_q;
    if (cfg_now != cfg_q) begin
      armed_n = 1'b0; primed_n = 1'b0; en_n = 1'b0;
    end else if (sync_slip) begin
      armed_n = 1'b1; primed_n = 1'b0; en_n = 1'b0;
    end else begin
      if (frame_sync) armed_n = 1'b1;
      if (armed_q && chan_start && ch_next == '0) primed_n = 1'b1;
      if (primed_q && chan_start && ch_idx == '0) en_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      armed_q  <= 1'b0;
      primed_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      cfg_q    <= cfg_now;
      armed_q  <= armed_n;
      primed_q <= primed_n;
      en_q     <= en_n;
    end
  end

  assign tx_en = en_q;
endmodule

// File: rtl/tdm_stream_tx_chk.sv
module tdm_stream_tx_chk #(
  parameter int RATE_W     = 2,
  parameter int BIT_SH     = 3,
  parameter int QTR_W      = 2,
  parameter int CH_W       = 8,
  parameter int BASE_CHANS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic [RATE_W-1:0] rate_sel,
  input logic              lsb_first,
  input logic [BIT_SH-1:0] adv_whole,
  input logic [QTR_W-1:0]  adv_quarter,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CH_W-1:0]   req_chan,
  input logic              tx_data,
  input logic              tx_en
);
  logic [RATE_W+BIT_SH+QTR_W:0] cfg_w;
  assign cfg_w = {rate_sel, lsb_first, adv_whole, adv_quarter};

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx_data);                                                  // R1
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_chan) < (BASE_CHANS << int'(rate_sel))));     // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);                               // R6
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && !frame_sync && $stable(cfg_w) |=> tx_en);                    // R8
  AST_CFG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_w) |=> !tx_en);                                          // R9
endmodule

bind tdm_stream_tx tdm_stream_tx_chk #(
  .RATE_W(RATE_W), .BIT_SH(BIT_SH), .QTR_W(tdm_tx_pkg::TX_QTR_W),
  .CH_W(CH_W), .BASE_CHANS(BASE_CHANS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_sel(rate_sel),
  .lsb_first(lsb_first), .adv_whole(adv_whole), .adv_quarter(adv_quarter),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
  .tx_data(tx_data), .tx_en(tx_en)
);

// File: tb/tb_tdm_stream_tx.sv
module tb_tdm_stream_tx;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 8192;

  logic clk = 0, rst_n = 0, frame_sync = 0, lsb_first = 0;
  logic [1:0] rate_sel = 2'd3, adv_quarter = 0;
  logic [2:0] adv_whole = 0;
  logic req_valid, req_ready = 0, rsp_valid = 0, tx_data, tx_en;
  logic [7:0] req_chan, rsp_data = 0;

  int checks = 0, fails = 0, bpos = 100;
  logic force_fp = 0, stall_en = 0, hs_q = 0;
  int stall_ch = 0;
  logic [7:0] hs_ch_q = 0;

  tdm_stream_tx dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench frame position, same rule as R5
  always @(posedge clk) bpos <= frame_sync ? 0 : (bpos + 1) % FRAME;
  always @(negedge clk) frame_sync <= (bpos == FRAME - 1) || force_fp;

  function automatic logic [7:0] pat(int c);
    return 8'(c * 37) ^ 8'h5A;
  endfunction
  function automatic int qclk();
    return 1 << (3 - int'(rate_sel));
  endfunction
  function automatic int slot_len();
    return 32 * qclk();
  endfunction
  function automatic int tpos(int p);
    return (p + (4 * int'(adv_whole) + int'(adv_quarter)) * qclk()) % FRAME;
  endfunction
  function automatic logic exp_bit(int p);
    int t = tpos(p);
    int c = t / slot_len();
    int k = (t % slot_len()) / (4 * qclk());
    logic [7:0] b = (stall_en && c == stall_ch) ? 8'hFF : pat(c);
    return lsb_first ? b[k] : b[7 - k];
  endfunction

  // responder: accepts a request unless it names the stalled channel, answers 1 cycle later
  always @(negedge clk) begin
    rsp_valid = hs_q;
    rsp_data  = pat(int'(hs_ch_q));
    hs_q      = req_valid && !(stall_en && int'(req_chan) == stall_ch);
    hs_ch_q   = req_chan;
    req_ready = hs_q;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_lock();
    while (tx_en !== 1'b1) @(negedge clk);
    chk(tpos(bpos) == 0, "R8 enable rises at channel 0 start", tpos(bpos), 0);
  endtask

  task automatic verify_frame(input string tag);
    int bad_bits = 0, bad_en = 0, bad_req = 0, a_bit = 0, e_bit = 0, t;
    logic prv = req_valid;
    for (int i = 0; i < FRAME; i++) begin
      if (tx_data !== exp_bit(bpos)) begin
        if (bad_bits == 0) begin a_bit = int'(tx_data); e_bit = int'(exp_bit(bpos)); end
        bad_bits++;
      end
      if (tx_en !== 1'b1) bad_en++;
      if (req_valid && !prv) begin
        t = tpos(bpos);
        if (t % slot_len() != 0 ||
            int'(req_chan) != (t / slot_len() + 1) % (32 << int'(rate_sel))) bad_req++;
      end
      prv = req_valid;
      @(negedge clk);
    end
    chk(bad_bits == 0, {tag, " R11 serial bits"}, a_bit, e_bit);
    chk(bad_en == 0, "R8 enable held for frame", bad_en, 0);
    chk(bad_req == 0, "R6 R4 request channel and timing", bad_req, 0);
  endtask

  task automatic set_cfg(input logic [1:0] r, input logic l, input logic [2:0] w,
                         input logic [1:0] q, input logic st, input int sc);
    rate_sel = r; lsb_first = l; adv_whole = w; adv_quarter = q;
    stall_en = st; stall_ch = sc;
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    chk(tx_en === 1'b0, "R1 reset tx_en", int'(tx_en), 0);
    chk(tx_data === 1'b1, "R1 reset tx_data", int'(tx_data), 1);
    chk(req_valid === 1'b0, "R1 reset req_valid", int'(req_valid), 0);
    rst_n = 1;
  endtask

  task automatic test_msb_fast();
    wait_lock();
    verify_frame("R2 R4 R5 msb 16M no lead");
  endtask

  task automatic test_cfg_change_lsb_slow();
    set_cfg(2'd0, 1'b1, 3'd7, 2'd3, 1'b0, 0);
    @(negedge clk);
    chk(tx_en === 1'b0, "R9 enable drops on config change", int'(tx_en), 0);
    chk(tx_data === 1'b1, "R1 idle high while disabled", int'(tx_data), 1);
    wait_lock();
    verify_frame("R3 R5 lsb 2M max lead");
  endtask

  task automatic test_stall();
    set_cfg(2'd2, 1'b0, 3'd3, 2'd1, 1'b1, 5);
    @(negedge clk);
    wait_lock();
    verify_frame("R7 R5 stalled channel 5 at 8M");
  endtask

  task automatic test_lsb_mid();
    set_cfg(2'd1, 1'b1, 3'd0, 2'd2, 1'b0, 0);
    @(negedge clk);
    wait_lock();
    verify_frame("R3 R4 R5 lsb 4M half-bit lead");
  endtask

  task automatic test_slip();
    repeat (1000) @(negedge clk);
    @(posedge clk); force_fp = 1;
    @(posedge clk); force_fp = 0;
    @(negedge clk);
    chk(tx_en === 1'b0, "R10 misaligned pulse drops enable", int'(tx_en), 1'b0);
  endtask

  initial begin
    test_reset();
    test_msb_fast();
    test_cfg_change_lsb_slow();
    test_stall();
    test_lsb_mid();
    test_slip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired R8 actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule